// File: doc/BRIEF.md
# Clear-on-Read Event Register Pair

This block keeps two event registers that hardware sources set one bit at a time and that a serial read path empties by reading them. One register records status and the other records errors. A read copies the selected register into an output holding word. On the same clock edge it clears part of that register. The status register keeps a fixed group of sticky bits and drops the rest. The error register drops every bit.

A host read is qualified by chip select and a read request together. Such a request often stays high for many cycles. A small state machine turns each qualified request into exactly one read event. The register is therefore copied once and cleared once. The output word never gets overwritten by the cleared contents on a later cycle of the same request.

A hardware set that lands in the same cycle as a clear takes priority over the clear. The event is then kept for the next read and is not lost.

Top module: `cor_status_pair`

Read conditioner states:
- `RD_IDLE`: no request.
- `RD_FIRE`: the one-cycle read event.
- `RD_HOLD`: the request is still high and has already been served.

Read conditioner transitions:
- `RD_IDLE`→`RD_FIRE` when `cs && rd_req`.
- `RD_FIRE`→`RD_HOLD` while the request stays high.
- `RD_FIRE`→`RD_IDLE` when the request has dropped.
- `RD_HOLD`→`RD_IDLE` when the request drops.
- `RD_HOLD` stays in `RD_HOLD` while the request stays high.

## Requirements
- R1: Synchronous active-high reset sets `status_q`, `error_q` and `rd_data` to zero.
- R2: A read of the status register (`reg_sel`=0) leaves bits 15, 14, 13, 5, 4 and 0 unchanged and clears every other bit. This is an AND with mask 16'hE031.
- R3: `rd_data` receives the value the selected register held before the clear. The read event occurs in the cycle after `cs && rd_req` is first sampled high. `rd_data` and the cleared register update on the clock edge that ends the event cycle.
- R4: A read of the error register (`reg_sel`=1) clears all 16 bits.
- R5: A qualified request held for any number of cycles produces exactly one read event. `rd_data` keeps the pre-clear value for the rest of the request and is not replaced by zero. A further read needs the request to drop first.
- R6: `rd_data` holds its value in every cycle without a read event.
- R7: `reg_sel` is sampled in the event cycle. Only the selected register is cleared. The other register keeps its contents and its pending sets.
- R8: A set bit (`status_set`/`error_set`) stays set until a read clears it. A set arriving in the same cycle as a clear wins, so that bit is 1 after the edge.
- R9: `cs` without `rd_req`, or `rd_req` without `cs`, causes no read. In that case `rd_data` and both registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select from the read path |
| rd_req | input | 1 | Read request from the read path |
| reg_sel | input | 1 | Register select: 0 status, 1 error |
| status_set | input | 16 | Per-bit set pulses for the status register |
| error_set | input | 16 | Per-bit set pulses for the error register |
| rd_data | output | 16 | Holding word loaded on each read event |
| status_q | output | 16 | Current status register contents |
| error_q | output | 16 | Current error register contents |

## Verification
Status reads use a value with bits both inside and outside the sticky mask. A read that kept or dropped the wrong bits is visible directly in `status_q`. Error reads use dense and sparse patterns, and a check on the unselected register separates a correct select from a clear that reaches both registers. Requests are held for one cycle and for six cycles, with fresh sets arriving mid-request. This shows whether a long request re-reads the register and zeroes `rd_data` or wipes the new events. Lone `cs` or lone `rd_req` pulses, and a set timed exactly on the event cycle, cover the qualification and the set-over-clear priority.

// File: rtl/cor_pkg.sv
package cor_pkg;
    localparam int DATA_W   = 16;
    localparam int NUM_REGS = 2;
    localparam int SEL_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    // Bits surviving a read, per register index (0 status, 1 error)
    localparam logic [DATA_W-1:0] STATUS_KEEP = 16'hE031;
    localparam logic [DATA_W-1:0] ERROR_KEEP  = '0;

    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_FIRE = 2'd1,
        RD_HOLD = 2'd2
    } rd_state_e;

    function automatic logic [DATA_W-1:0] keep_mask(input int idx);
        return (idx == 0) ? STATUS_KEEP : ERROR_KEEP;
    endfunction
endpackage

// File: rtl/cor_strobe_fsm.sv
module cor_strobe_fsm
    import cor_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic rd_req,
    output logic fire
);
    rd_state_e state_q;
    rd_state_e state_d;
    logic      qual;

    assign qual = cs && rd_req;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (qual)  state_d = RD_FIRE;
            RD_FIRE: state_d = qual ? RD_HOLD : RD_IDLE;
            RD_HOLD: if (!qual) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= RD_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        fire = (state_q == RD_FIRE);
    end
endmodule

// File: rtl/cor_event_reg.sv
module cor_event_reg #(
    parameter int              WIDTH = 16,
    parameter logic [WIDTH-1:0] KEEP = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_bits,
    input  logic             clr_en,
    output logic [WIDTH-1:0] value_q
);
    logic [WIDTH-1:0] survive;

    always_comb begin
        survive = clr_en ? (value_q & KEEP) : value_q;
    end

    // Set is ORed after the clear so a coincident event is retained
    always_ff @(posedge clk) begin
        if (rst) value_q <= '0;
        else     value_q <= survive | set_bits;
    end
endmodule

// File: rtl/cor_status_pair.sv
module cor_status_pair
    import cor_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd_req,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] status_set,
    input  logic [DATA_W-1:0] error_set,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] status_q,
    output logic [DATA_W-1:0] error_q
);
    logic                          rd_fire;
    logic [NUM_REGS-1:0][DATA_W-1:0] set_vec;
    logic [NUM_REGS-1:0][DATA_W-1:0] reg_vec;
    logic [SEL_W-1:0]              sel_idx;

    assign sel_idx    = SEL_W'(reg_sel);
    assign set_vec[0] = status_set;
    assign set_vec[1] = error_set;

    cor_strobe_fsm u_strobe (
        .clk    (clk),
        .rst    (rst),
        .cs     (cs),
        .rd_req (rd_req),
        .fire   (rd_fire)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        cor_event_reg #(
            .WIDTH (DATA_W),
            .KEEP  (keep_mask(g))
        ) u_reg (
            .clk      (clk),
            .rst      (rst),
            .set_bits (set_vec[g]),
            .clr_en   (rd_fire && (sel_idx == SEL_W'(g))),
            .value_q  (reg_vec[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_data <= '0;
        else if (rd_fire) rd_data <= reg_vec[sel_idx];
    end

    assign status_q = reg_vec[0];
    assign error_q  = reg_vec[1];
endmodule

// File: rtl/cor_status_pair_chk.sv
module cor_status_pair_chk
    import cor_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fire,
    input logic              reg_sel,
    input logic [DATA_W-1:0] status_set,
    input logic [DATA_W-1:0] error_set,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] status_q,
    input logic [DATA_W-1:0] error_q
);
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire); // R5
    AST_PRECLEAR_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (fire && !reg_sel) |=> rd_data == $past(status_q)); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (fire && !reg_sel) |=> status_q == (($past(status_q) & 16'hE031) | $past(status_set))); // R2
    AST_ERROR_WIPE: assert property (@(posedge clk) disable iff (rst)
        (fire && reg_sel) |=> error_q == $past(error_set)); // R4
    AST_OTHER_KEPT: assert property (@(posedge clk) disable iff (rst)
        (fire && !reg_sel) |=> error_q == ($past(error_q) | $past(error_set))); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(rd_data)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (status_set != '0) |=> ((status_q & $past(status_set)) == $past(status_set))); // R8
endmodule

bind cor_status_pair cor_status_pair_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .fire       (rd_fire),
    .reg_sel    (reg_sel),
    .status_set (status_set),
    .error_set  (error_set),
    .rd_data    (rd_data),
    .status_q   (status_q),
    .error_q    (error_q)
);

// File: tb/test_cor_status_pair.sv
module test_cor_status_pair;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0;
    logic        rd_req = 1'b0;
    logic        reg_sel = 1'b0;
    logic [15:0] status_set = '0;
    logic [15:0] error_set = '0;
    logic [15:0] rd_data, status_q, error_q;

    logic [15:0] st_m = '0;
    logic [15:0] er_m = '0;
    logic [15:0] rd_m = '0;
    int nvec = 0;
    int nbad = 0;
    localparam logic [15:0] KEEP = 16'hE031;

    always #10 clk = ~clk;

    cor_status_pair i_cor_status_pair (
        .clk(clk), .rst(rst), .cs(cs), .rd_req(rd_req), .reg_sel(reg_sel),
        .status_set(status_set), .error_set(error_set),
        .rd_data(rd_data), .status_q(status_q), .error_q(error_q)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, rd_data, rd_m);
        chk(req, status_q, st_m);
        chk(req, error_q, er_m);
    endtask

    task automatic set_pulse(input logic [15:0] s, input logic [15:0] e);
        status_set = s; error_set = e;
        @(negedge clk);
        status_set = '0; error_set = '0;
        st_m |= s; er_m |= e;
    endtask

    // qualified read held for 'hold' cycles
    task automatic do_read(input logic sel, input int hold, input string req);
        reg_sel = sel; cs = 1'b1; rd_req = 1'b1;
        repeat (hold) @(negedge clk);
        cs = 1'b0; rd_req = 1'b0;
        repeat (2) @(negedge clk);
        if (!sel) begin rd_m = st_m; st_m &= KEEP; end
        else      begin rd_m = er_m; er_m = '0; end
        chk_all(req);
    endtask

    task automatic t_reset();
        chk_all("R1 reset");
    endtask

    task automatic t_status_read();
        set_pulse(16'hFFFF, 16'h0000);
        do_read(1'b0, 1, "R2 status mask");
        chk("R3 preclear", rd_data, 16'hFFFF);
        set_pulse(16'h5A5A, 16'h0000);
        do_read(1'b0, 1, "R2 sparse status");
    endtask

    task automatic t_error_read();
        set_pulse(16'h0000, 16'hBEEF);
        do_read(1'b1, 2, "R4 error wipe");
        set_pulse(16'h0000, 16'h0001);
        do_read(1'b1, 1, "R4 single bit");
    endtask

    task automatic t_select();
        set_pulse(16'h0F0F, 16'h8421);
        do_read(1'b0, 1, "R7 status only");
        chk("R7 error untouched", error_q, 16'h8421);
        set_pulse(16'h1234, 16'h0000);
        do_read(1'b1, 1, "R7 error only");
    endtask

    task automatic t_long_hold();
        logic [15:0] pre;
        set_pulse(16'hFFFF, 16'h0000);
        pre = st_m;
        reg_sel = 1'b0; cs = 1'b1; rd_req = 1'b1;
        repeat (2) @(negedge clk);
        st_m &= KEEP; rd_m = pre;
        chk("R5 first capture", rd_data, pre);
        set_pulse(16'h0ACE, 16'h0000);
        repeat (3) @(negedge clk);
        chk("R5 no zero overwrite", rd_data, pre);
        chk("R5 no second clear", status_q, st_m);
        cs = 1'b0; rd_req = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R6 hold after long read");
        do_read(1'b0, 1, "R5 new read after drop");
    endtask

    task automatic t_unqualified();
        set_pulse(16'h00C0, 16'h0300);
        cs = 1'b1;
        repeat (3) @(negedge clk);
        cs = 1'b0; rd_req = 1'b1;
        repeat (3) @(negedge clk);
        rd_req = 1'b0;
        repeat (2) @(negedge clk);
        chk_all("R9 no read without both");
    endtask

    task automatic t_set_wins();
        logic [15:0] pre;
        set_pulse(16'h0F00, 16'h0000);
        pre = st_m;
        reg_sel = 1'b0; cs = 1'b1; rd_req = 1'b1;
        @(negedge clk);                     // event cycle now
        cs = 1'b0; rd_req = 1'b0;
        status_set = 16'h0200;
        @(negedge clk);
        status_set = '0;
        st_m = (pre & KEEP) | 16'h0200; rd_m = pre;
        chk("R8 set beats clear", status_q, st_m);
        chk("R3 capture", rd_data, pre);
        repeat (2) @(negedge clk);
        chk("R8 sticky", status_q, st_m);
    endtask

    initial begin
        #4000000;
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_status_read();
        t_error_read();
        t_select();
        t_long_hold();
        t_unqualified();
        t_set_wins();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule